// File: doc/BRIEF.md
# Program Counter with Address Select

This block produces the instruction address for a small sequenced datapath. It holds a 16-bit program counter built from a ripple chain of 4-bit up/down stages. Each stage hands a carry to the next when counting up and a borrow when counting down. Alongside the counter sits an address hold register that can be loaded one half at a time or as a whole word.

A select bit chooses whether the counter or the hold register supplies the outgoing address. A bus-enable bit decides whether that address is placed on the shared address bus. All requests arrive as single-cycle strobes decoded from the control word. Every change takes effect on the rising clock edge on which the strobe is sampled.

When several counter strobes arrive together, a fixed priority picks exactly one of them. A one-cycle wrap flag marks the cycle after the counter rolls over at either end of its range.

Top module: `pc_addr_select`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, the counter reads 0x0000, the hold register reads 0x0000, `wrap_pulse` is 0 and `bus_drive` follows `bus_en`.
- R2: `cnt_clear` sets the counter to 0x0000 on the next edge, whatever other counter strobes are high.
- R3: `cnt_preset` loads `load_data[15:0]` into the counter. It wins over `cnt_inc` and `cnt_dec` but loses to `cnt_clear`.
- R4: `cnt_inc` adds one modulo 2^16, with the carry rippling across 4-bit stage boundaries (for example 0x0FFF becomes 0x1000).
- R5: `cnt_dec` subtracts one modulo 2^16, with the borrow rippling across stages. When `cnt_inc` and `cnt_dec` are both high, only the increment is applied.
- R6: `wrap_pulse` is 1 for exactly the cycle after an increment from 0xFFFF or a decrement from 0x0000, and is 0 after any other cycle, including clears and presets.
- R7: `hold_ld_word` loads `load_data[15:0]` into the hold register.
- R8: `hold_ld_lo` writes `load_data[7:0]` into hold bits [7:0] and `hold_ld_hi` writes `load_data[7:0]` into hold bits [15:8]. The other half is left unchanged. Both byte strobes together write both halves. `hold_ld_word` overrides both byte strobes.
- R9: `addr_out` equals the hold register when `addr_sel` is 1 and the counter when `addr_sel` is 0, in the same cycle.
- R10: `bus_addr` equals `addr_out` and `bus_drive` is 1 while `bus_en` is 1. Otherwise `bus_addr` is 0x0000 and `bus_drive` is 0. The counter keeps stepping while the bus is disabled.
- R11: With no counter strobe high, the counter holds its value. With no hold strobe high, the hold register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_clear | input | 1 | Counter clear strobe (highest priority) |
| cnt_preset | input | 1 | Counter parallel load strobe |
| cnt_inc | input | 1 | Counter step up strobe |
| cnt_dec | input | 1 | Counter step down strobe |
| hold_ld_lo | input | 1 | Load low half of hold register |
| hold_ld_hi | input | 1 | Load high half of hold register |
| hold_ld_word | input | 1 | Load whole hold register |
| load_data | input | 16 | Shared load value for preset and hold register |
| addr_sel | input | 1 | 1 selects hold register, 0 selects counter |
| bus_en | input | 1 | Enables driving the address bus |
| pc_value | output | 16 | Current counter value |
| hold_value | output | 16 | Current hold register value |
| addr_out | output | 16 | Selected address |
| bus_addr | output | 16 | Address bus value, zero when not driven |
| bus_drive | output | 1 | High while the address bus is driven |
| wrap_pulse | output | 1 | One-cycle rollover marker |

## Verification
Two counter requests can land on the same edge. A preset can coincide with an increment, a clear with a preset, and an increment with a decrement. On the hold side, a word load can coincide with a byte load. Each of these pairs is driven on purpose in directed cycles and then again by random strobes over a few hundred cycles. A behavioural model in the bench applies the stated priority and is compared on every clock. A rollover that coincides with a disabled bus is also driven, to show that counting and the wrap pulse do not depend on the bus.

// File: rtl/pc_addr_pkg.sv
// Package: shared types for the program counter and address select block.
// Assumes: counter stages all receive the same decoded operation each cycle.
package pc_addr_pkg;

    // Decoded operation applied to every counter stage in one cycle.
    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_LOAD = 2'd1,
        CNT_UP   = 2'd2,
        CNT_DOWN = 2'd3
    } cnt_op_e;

    // Resolve simultaneous counter strobes: clear, preset, up, down.
    function automatic cnt_op_e resolve_op(input logic clr, input logic pre,
                                           input logic up, input logic dn);
        if (clr || pre) return CNT_LOAD;
        if (up)         return CNT_UP;
        if (dn)         return CNT_DOWN;
        return CNT_HOLD;
    endfunction

endpackage

// File: rtl/pc_nibble_stage.sv
// Module: one up/down counter stage of STAGE_W bits.
// Steps only when step_in is high (ripple from lower stages);
// loads unconditionally on CNT_LOAD. ripple_out tells the next stage to step.
// Assumes: synchronous active-low reset.
module pc_nibble_stage
    import pc_addr_pkg::*;
#(
    parameter int STAGE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  cnt_op_e            op,
    input  logic [STAGE_W-1:0] load_val,
    input  logic               step_in,
    output logic [STAGE_W-1:0] q,
    output logic               ripple_out
);

    localparam logic [STAGE_W-1:0] ALL_ONES = {STAGE_W{1'b1}};
    localparam logic [STAGE_W-1:0] ALL_ZERO = {STAGE_W{1'b0}};
    localparam logic [STAGE_W-1:0] ONE      = {{(STAGE_W-1){1'b0}}, 1'b1};

    // Stage state: reset, load, or step in the decoded direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= ALL_ZERO;
        end else begin
            unique case (op)
                CNT_LOAD: q <= load_val;
                CNT_UP:   if (step_in) q <= q + ONE;
                CNT_DOWN: if (step_in) q <= q - ONE;
                default:  q <= q;
            endcase
        end
    end

    // Carry on terminal-up, borrow on terminal-down, passed upward.
    always_comb begin
        unique case (op)
            CNT_UP:   ripple_out = step_in && (q == ALL_ONES);
            CNT_DOWN: ripple_out = step_in && (q == ALL_ZERO);
            default:  ripple_out = 1'b0;
        endcase
    end

endmodule

// File: rtl/pc_count_chain.sv
// Module: program counter made of cascaded up/down stages.
// Applies one operation per cycle by priority (clear, preset, up, down).
// Raises wrap_q for one cycle after a rollover at either end.
// Assumes: WIDTH is a multiple of STAGE_W.
module pc_count_chain
    import pc_addr_pkg::*;
#(
    parameter int WIDTH   = 16,
    parameter int STAGE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             pre,
    input  logic             up,
    input  logic             dn,
    input  logic [WIDTH-1:0] pre_val,
    output logic [WIDTH-1:0] count,
    output logic             wrap_q
);

    localparam int NSTAGE = WIDTH / STAGE_W;

    cnt_op_e            op;
    logic [WIDTH-1:0]   load_word;
    logic [NSTAGE:0]    ripple;

    // Decode strobes into one stage operation and its load word.
    always_comb begin
        op        = resolve_op(clr, pre, up, dn);
        load_word = clr ? '0 : pre_val;
    end

    assign ripple[0] = 1'b1;

    // Chain of stages; each steps when every lower stage is terminal.
    for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
        pc_nibble_stage #(.STAGE_W(STAGE_W)) u_stage (
            .clk        (clk),
            .rst_n      (rst_n),
            .op         (op),
            .load_val   (load_word[i*STAGE_W +: STAGE_W]),
            .step_in    (ripple[i]),
            .q          (count[i*STAGE_W +: STAGE_W]),
            .ripple_out (ripple[i+1])
        );
    end

    // Register the top-stage ripple as the one-cycle rollover marker.
    always_ff @(posedge clk) begin
        if (!rst_n) wrap_q <= 1'b0;
        else        wrap_q <= ripple[NSTAGE];
    end

endmodule

// File: rtl/addr_hold_reg.sv
// Module: address hold register loaded by halves or as a whole word.
// Half loads take their value from the low half of din; a word load wins
// over half loads. Assumes WIDTH is even.
module addr_hold_reg #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_lo,
    input  logic             ld_hi,
    input  logic             ld_word,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);

    localparam int HALF = WIDTH / 2;

    logic [1:0]           half_we;
    logic [HALF-1:0]      half_src [2];

    // Per-half write enables and sources.
    always_comb begin
        half_we[0]  = ld_word || ld_lo;
        half_we[1]  = ld_word || ld_hi;
        half_src[0] = din[HALF-1:0];
        half_src[1] = ld_word ? din[WIDTH-1:HALF] : din[HALF-1:0];
    end

    // One storage slice per half.
    for (genvar h = 0; h < 2; h++) begin : g_half
        // Half storage: reset to zero, write when enabled.
        always_ff @(posedge clk) begin
            if (!rst_n)          q[h*HALF +: HALF] <= '0;
            else if (half_we[h]) q[h*HALF +: HALF] <= half_src[h];
        end
    end

endmodule

// File: rtl/pc_addr_select.sv
// Module (top): program counter, address hold register, address selector
// and gated bus output. Assumes all strobes are synchronous to clk and that
// the bus value reads as zero when not driven.
module pc_addr_select #(
    parameter int ADDR_W  = 16,
    parameter int STAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_clear,
    input  logic              cnt_preset,
    input  logic              cnt_inc,
    input  logic              cnt_dec,
    input  logic              hold_ld_lo,
    input  logic              hold_ld_hi,
    input  logic              hold_ld_word,
    input  logic [ADDR_W-1:0] load_data,
    input  logic              addr_sel,
    input  logic              bus_en,
    output logic [ADDR_W-1:0] pc_value,
    output logic [ADDR_W-1:0] hold_value,
    output logic [ADDR_W-1:0] addr_out,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_drive,
    output logic              wrap_pulse
);

    pc_count_chain #(.WIDTH(ADDR_W), .STAGE_W(STAGE_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clear),
        .pre     (cnt_preset),
        .up      (cnt_inc),
        .dn      (cnt_dec),
        .pre_val (load_data),
        .count   (pc_value),
        .wrap_q  (wrap_pulse)
    );

    addr_hold_reg #(.WIDTH(ADDR_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_lo   (hold_ld_lo),
        .ld_hi   (hold_ld_hi),
        .ld_word (hold_ld_word),
        .din     (load_data),
        .q       (hold_value)
    );

    // Address source selection and bus gating.
    always_comb begin
        addr_out  = addr_sel ? hold_value : pc_value;
        bus_drive = bus_en;
        bus_addr  = bus_en ? addr_out : '0;
    end

endmodule

// File: rtl/pc_addr_select_chk.sv
// Checker: temporal properties of pc_addr_select, bound to every instance.
module pc_addr_select_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnt_clear,
    input logic              cnt_preset,
    input logic              cnt_inc,
    input logic              cnt_dec,
    input logic              hold_ld_lo,
    input logic              hold_ld_hi,
    input logic              hold_ld_word,
    input logic [ADDR_W-1:0] load_data,
    input logic              addr_sel,
    input logic              bus_en,
    input logic [ADDR_W-1:0] pc_value,
    input logic [ADDR_W-1:0] hold_value,
    input logic [ADDR_W-1:0] addr_out,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_drive,
    input logic              wrap_pulse
);

    localparam int HALF = ADDR_W / 2;

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clear |=> pc_value == '0); // R2

    AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_clear && cnt_preset) |=> pc_value == $past(load_data)); // R3

    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_clear && !cnt_preset && cnt_inc) |=> pc_value == $past(pc_value) + 1'b1); // R4

    AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_clear && !cnt_preset && !cnt_inc && cnt_dec) |=> pc_value == $past(pc_value) - 1'b1); // R5

    AST_WRAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_clear && !cnt_preset && ((cnt_inc && pc_value == '1) || (!cnt_inc && cnt_dec && pc_value == '0)))
        |=> wrap_pulse); // R6

    AST_WRAP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_clear || cnt_preset || (!cnt_inc && !cnt_dec)) |=> !wrap_pulse); // R6

    AST_WORD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ld_word |=> hold_value == $past(load_data)); // R7

    AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_ld_lo && !hold_ld_hi && !hold_ld_word) |=>
        hold_value[ADDR_W-1:HALF] == $past(hold_value[ADDR_W-1:HALF])); // R8

    AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_ld_hi && !hold_ld_lo && !hold_ld_word) |=>
        hold_value[HALF-1:0] == $past(hold_value[HALF-1:0])); // R8

    AST_SEL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        addr_out == (addr_sel ? hold_value : pc_value)); // R9

    AST_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |-> (bus_addr == '0 && !bus_drive)); // R10

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_clear && !cnt_preset && !cnt_inc && !cnt_dec) |=> $stable(pc_value)); // R11

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_ld_lo && !hold_ld_hi && !hold_ld_word) |=> $stable(hold_value)); // R11

endmodule

bind pc_addr_select pc_addr_select_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_pc_addr_select.sv
module sim_pc_addr_select;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_clear = 0, cnt_preset = 0, cnt_inc = 0, cnt_dec = 0;
    logic        hold_ld_lo = 0, hold_ld_hi = 0, hold_ld_word = 0;
    logic [15:0] load_data = 16'h0;
    logic        addr_sel = 0, bus_en = 0;
    logic [15:0] pc_value, hold_value, addr_out, bus_addr;
    logic        bus_drive, wrap_pulse;

    int n_run = 0;
    int n_fail = 0;

    // Reference state
    int m_pc = 0;
    int m_hold = 0;
    int m_wrap = 0;

    always #2 clk = ~clk;

    pc_addr_select u0 (.*);

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        int ea;
        ea = addr_sel ? m_hold : m_pc;
        chk(tag, "pc_value", int'(pc_value), m_pc);
        chk(tag, "hold_value", int'(hold_value), m_hold);
        chk(tag, "wrap_pulse", int'(wrap_pulse), m_wrap);
        chk(tag, "addr_out", int'(addr_out), ea);
        chk(tag, "bus_addr", int'(bus_addr), bus_en ? ea : 0);
        chk(tag, "bus_drive", int'(bus_drive), int'(bus_en));
    endtask

    // One cycle: drive at negedge, model at posedge, compare at next negedge.
    task automatic step(input logic clr, input logic pre, input logic inc, input logic dec,
                        input logic llo, input logic lhi, input logic lwd,
                        input logic [15:0] d, input logic sel, input logic en,
                        input string tag);
        cnt_clear = clr; cnt_preset = pre; cnt_inc = inc; cnt_dec = dec;
        hold_ld_lo = llo; hold_ld_hi = lhi; hold_ld_word = lwd;
        load_data = d; addr_sel = sel; bus_en = en;
        @(posedge clk);
        m_wrap = 0;
        if (clr) m_pc = 0;
        else if (pre) m_pc = int'(d);
        else if (inc) begin m_wrap = (m_pc == 16'hFFFF); m_pc = (m_pc + 1) & 16'hFFFF; end
        else if (dec) begin m_wrap = (m_pc == 0); m_pc = (m_pc + 16'hFFFF) & 16'hFFFF; end
        if (lwd) m_hold = int'(d);
        else begin
            if (llo) m_hold = (m_hold & 16'hFF00) | int'(d[7:0]);
            if (lhi) m_hold = (m_hold & 16'h00FF) | (int'(d[7:0]) << 8);
        end
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : stim
        // R1: reset state
        repeat (3) @(negedge clk);
        compare_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1");

        step(0,1,0,0, 0,0,0, 16'h0FFE, 0,1, "R3");
        step(0,0,1,0, 0,0,0, 16'h0,    0,1, "R4");
        step(0,0,1,0, 0,0,0, 16'h0,    0,1, "R4");   // 0FFF -> 1000
        step(0,0,0,1, 0,0,0, 16'h0,    0,1, "R5");   // 1000 -> 0FFF
        step(0,0,1,1, 0,0,0, 16'h0,    0,1, "R5");   // inc wins
        step(0,1,1,0, 0,0,0, 16'h7A5C, 0,1, "R3");   // preset wins
        step(0,0,0,0, 0,0,0, 16'h1111, 0,1, "R11");
        step(1,1,1,1, 0,0,0, 16'h2222, 0,1, "R2");   // clear wins
        step(0,0,0,1, 0,0,0, 16'h0,    0,1, "R6");   // 0000 -> FFFF wrap
        step(0,0,0,0, 0,0,0, 16'h0,    0,1, "R6");   // pulse drops
        step(0,0,1,0, 0,0,0, 16'h0,    0,0, "R6");   // FFFF -> 0 wrap, bus off
        step(0,0,0,1, 0,0,0, 16'h0,    0,1, "R6");   // back-to-back wrap
        step(0,1,0,0, 0,0,0, 16'hFFFF, 0,1, "R6");   // preset: no pulse
        step(0,0,1,0, 0,0,0, 16'h0,    0,0, "R10");  // counts with bus off
        step(0,0,1,0, 0,0,0, 16'h0,    0,0, "R10");

        step(0,0,0,0, 0,0,1, 16'hABCD, 1,1, "R7");
        step(0,0,0,0, 1,0,0, 16'h5634, 1,1, "R8");   // -> AB34
        step(0,0,0,0, 0,1,0, 16'h9912, 1,1, "R8");   // -> 1234
        step(0,0,0,0, 1,1,0, 16'h00C3, 1,1, "R8");   // -> C3C3
        step(0,0,0,0, 1,1,1, 16'hBEEF, 1,1, "R8");   // word wins
        step(0,0,0,0, 0,0,0, 16'h0,    1,1, "R11");
        step(0,0,0,0, 0,0,0, 16'h0,    0,1, "R9");
        step(0,0,0,0, 0,0,0, 16'h0,    1,1, "R9");
        step(0,0,0,0, 0,0,0, 16'h0,    1,0, "R10");

        // Mixed random strobes, including coincident requests.
        for (int i = 0; i < 400; i++) begin
            logic [15:0] rv;
            logic [9:0]  s;
            rv = 16'($urandom);
            s  = 10'($urandom);
            if (i % 40 == 0) rv = (i % 80 == 0) ? 16'hFFFE : 16'h0001;
            step(s[0] & s[1] & s[2], s[3] & s[4], s[5], s[6],
                 s[7] & s[1], s[8] & s[2], s[9] & s[3] & s[4], rv,
                 s[2], s[4] | s[6], "R5");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule